// File: doc/BRIEF.md
# Event-driven power supervisor

The supervisor controls the clock gate and the supply level of up to eight functional units on a low-power chip. It does nothing while no event is waiting. An event can come from the neighbour radio, from a sensor, from a software request, or from the internal timewheel. When one arrives, a short microcoded sequence runs. Each microcode word sends one power-control command to one unit. The command sets that unit's target supply level (off, retention or full) and says whether its clock should run.

The timewheel is an always-on 32-bit counter with four compare registers. When an armed compare register matches the count, a timer event is raised through the same pending-event path as the external sources. This lets any unit be powered down and woken again later without software. A one-shot alarm disarms itself when it fires. A periodic alarm stays armed and fires again each time the counter comes back to the same value.

The microcode store is loaded through a valid/ready port. Ready is high only while the sequencer is idle. A word is written on a clock edge where both valid and ready are high. While a sequence runs, ready is low and the writer must hold the word until ready returns. The event inputs and the alarm programming port are plain control pins with no handshake.

Top module: `pwr_supervisor`

## Requirements
- R1: After reset, every unit supply is off (code 0), every unit clock is gated, all four alarms are disarmed, the timewheel reads 0 and the microcode port is ready.
- R2: The timewheel increments by exactly one on every clock after reset.
- R3: An armed alarm whose compare value equals the timewheel raises a timer event. A one-shot alarm disarms itself on that edge. A periodic alarm stays armed.
- R4: Events are latched into a pending set. The sequencer starts only when an event is pending. With nothing pending, busy stays low and no unit output changes.
- R5: Pending events are served one sequence at a time, in this order: timer (bit 0) first, then radio (bit 1), then sensor (bit 2), then software (bit 3). The start addresses are 0, 4, 8 and 12 respectively.
- R6: A microcode word has this layout: bits [2:0] unit index, bits [4:3] supply level, bit 5 clock request, bit 6 end of sequence. The level codes are 0 off, 1 retention and 2 full; code 3 is applied as full. One word executes per cycle. The first word of a sequence takes effect on the second clock edge after the edge that latched the event.
- R7: A unit's clock is enabled only while its supply is full, and no earlier than one cycle after the supply reached full.
- R8: When a unit must leave the running state, its clock is gated first and its supply is changed on the following cycle.
- R9: Microcode words are written only on an edge where valid and ready are both high. Ready is low while a sequence is running, so a word offered then does not reach the store.
- R10: A word that requests the clock together with a level below full leaves that unit's clock gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| radio_evt | input | 1 | Neighbour-radio wake event, sampled each edge |
| sensor_evt | input | 1 | Sensor wake event, sampled each edge |
| sw_evt | input | 1 | Software wake request, sampled each edge |
| alarm_wr | input | 1 | Write strobe for one alarm register |
| alarm_sel | input | 2 | Alarm register to write |
| alarm_cmp | input | 32 | Compare value |
| alarm_arm | input | 1 | Arm (1) or disarm (0) the selected alarm |
| alarm_oneshot | input | 1 | Disarm on first match when set |
| uc_valid | input | 1 | Microcode word offered |
| uc_ready | output | 1 | Store can accept a word (sequencer idle) |
| uc_addr | input | 4 | Microcode address to write |
| uc_word | input | 7 | Microcode word, layout as in R6 |
| time_now | output | 32 | Current timewheel count |
| alarm_armed | output | 4 | Armed flag per alarm |
| busy | output | 1 | A sequence is running |
| unit_supply | output | 16 | Two-bit supply level per unit, unit n at bits [2n+1:2n] |
| unit_clk_en | output | 8 | Clock enable per unit |

## Verification
The hardest situation to reach from the ports is several sources waiting at once, so that the service order decides the final state. The stimulus raises radio, sensor and software events on a single edge. The radio sequence powers a unit up, and the sensor sequence powers the same unit down, so only the correct order leaves it off. A second case makes a one-shot alarm match on the same edge as a sensor event, by computing the compare value from the timewheel count read at the ports. A behavioural reference model checks every output on every clock. This also catches off-by-one timing in the gate-then-lower and raise-then-ungate orderings.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_RET  = 2'd1,
    PWR_FULL = 2'd2,
    PWR_RSVD = 2'd3
  } pwr_lvl_e;

  // bit 6 end, bit 5 clock request, bits 4:3 level, bits 2:0 unit
  typedef struct packed {
    logic       last;
    logic       clk_req;
    logic [1:0] lvl;
    logic [2:0] unit;
  } uc_word_t;

  localparam int UC_WORD_W = $bits(uc_word_t);

  // event source bit positions, lowest index served first
  localparam int SRC_TIMER  = 0;
  localparam int SRC_RADIO  = 1;
  localparam int SRC_SENSOR = 2;
  localparam int SRC_SW     = 3;
  localparam int NUM_SRC    = 4;

endpackage

// File: rtl/pwr_timewheel.sv
module pwr_timewheel #(
  parameter int TW_W       = 32,
  parameter int NUM_ALARMS = 4,
  localparam int SEL_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [SEL_W-1:0]      sel,
  input  logic [TW_W-1:0]       cmp,
  input  logic                  arm,
  input  logic                  oneshot,
  output logic [TW_W-1:0]       now,
  output logic [NUM_ALARMS-1:0] armed,
  output logic                  fire
);

  logic [NUM_ALARMS-1:0] hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    logic [TW_W-1:0] cmp_r;
    logic            en_r;
    logic            os_r;

    assign hits[i]  = en_r && (now == cmp_r);
    assign armed[i] = en_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_r <= '0;
        en_r  <= 1'b0;
        os_r  <= 1'b0;
      end else if (wr && (sel == SEL_W'(i))) begin
        cmp_r <= cmp;
        en_r  <= arm;
        os_r  <= oneshot;
      end else if (hits[i] && os_r) begin
        en_r  <= 1'b0;
      end
    end
  end

  assign fire = |hits;

endmodule

// File: rtl/pwr_event_arb.sv
module pwr_event_arb #(
  parameter int NUM_SRC = 4,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic               take,
  output logic               pend_any,
  output logic [IDX_W-1:0]   win_idx
);

  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] clr;

  always_comb begin
    win_idx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (pend_q[k]) win_idx = IDX_W'(k);
    end
  end

  assign pend_any = |pend_q;
  assign clr      = take ? (NUM_SRC'(1) << win_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | evt_in;
  end

endmodule

// File: rtl/pwr_useq.sv
module pwr_useq
  import pwr_sup_pkg::*;
#(
  parameter int UC_AW   = 4,
  parameter int NSRC    = 4,
  parameter logic [NSRC*UC_AW-1:0] VEC_TABLE = {4'd12, 4'd8, 4'd4, 4'd0},
  localparam int UC_DEPTH = 1 << UC_AW,
  localparam int IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pend_any,
  input  logic [IDX_W-1:0]     win_idx,
  input  logic                 uc_valid,
  input  logic [UC_AW-1:0]     uc_addr,
  input  logic [UC_WORD_W-1:0] uc_word,
  output logic                 uc_ready,
  output logic                 take,
  output logic                 busy,
  output logic                 cmd_valid,
  output uc_word_t             cmd
);

  typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_e;

  localparam logic [UC_WORD_W-1:0] WORD_RST = {1'b1, {(UC_WORD_W-1){1'b0}}};

  sq_state_e            state;
  logic [UC_AW-1:0]     pc;
  logic [UC_WORD_W-1:0] mem [UC_DEPTH];

  assign uc_ready  = (state == SQ_IDLE);
  assign busy      = (state == SQ_RUN);
  assign take      = (state == SQ_IDLE) && pend_any;
  assign cmd_valid = (state == SQ_RUN);
  assign cmd       = uc_word_t'(mem[pc]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < UC_DEPTH; a++) mem[a] <= WORD_RST;
    end else if (uc_valid && uc_ready) begin
      mem[uc_addr] <= uc_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      pc    <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (pend_any) begin
          pc    <= VEC_TABLE[int'(win_idx)*UC_AW +: UC_AW];
          state <= SQ_RUN;
        end
        SQ_RUN: begin
          if (cmd.last) state <= SQ_IDLE;
          else          pc    <= pc + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwr_unit_ctrl.sv
module pwr_unit_ctrl
  import pwr_sup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_lvl,
  input  logic       cmd_clk,
  output logic [1:0] supply,
  output logic       clk_en
);

  pwr_lvl_e tl_q, t_lvl, sup_q;
  logic     tc_q, t_clk, clk_q;

  always_comb begin
    if (cmd_valid) begin
      t_lvl = (cmd_lvl == PWR_RSVD) ? PWR_FULL : pwr_lvl_e'(cmd_lvl);
      t_clk = cmd_clk;
    end else begin
      t_lvl = tl_q;
      t_clk = tc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q  <= PWR_OFF;
      tc_q  <= 1'b0;
      sup_q <= PWR_OFF;
      clk_q <= 1'b0;
    end else begin
      tl_q <= t_lvl;
      tc_q <= t_clk;
      if (clk_q && ((t_lvl != PWR_FULL) || !t_clk)) begin
        clk_q <= 1'b0;
      end else if (sup_q != t_lvl) begin
        sup_q <= t_lvl;
      end else if (t_clk && (t_lvl == PWR_FULL) && !clk_q) begin
        clk_q <= 1'b1;
      end
    end
  end

  assign supply = sup_q;
  assign clk_en = clk_q;

endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor
  import pwr_sup_pkg::*;
#(
  parameter int NUM_UNITS  = 8,
  parameter int TW_W       = 32,
  parameter int NUM_ALARMS = 4,
  parameter int UC_AW      = 4,
  parameter logic [NUM_SRC*UC_AW-1:0] VEC_TABLE = {4'd12, 4'd8, 4'd4, 4'd0},
  localparam int SEL_W     = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   radio_evt,
  input  logic                   sensor_evt,
  input  logic                   sw_evt,
  input  logic                   alarm_wr,
  input  logic [SEL_W-1:0]       alarm_sel,
  input  logic [TW_W-1:0]        alarm_cmp,
  input  logic                   alarm_arm,
  input  logic                   alarm_oneshot,
  input  logic                   uc_valid,
  output logic                   uc_ready,
  input  logic [UC_AW-1:0]       uc_addr,
  input  logic [UC_WORD_W-1:0]   uc_word,
  output logic [TW_W-1:0]        time_now,
  output logic [NUM_ALARMS-1:0]  alarm_armed,
  output logic                   busy,
  output logic [2*NUM_UNITS-1:0] unit_supply,
  output logic [NUM_UNITS-1:0]   unit_clk_en
);

  localparam int IDX_W = $clog2(NUM_SRC);

  logic               tw_fire;
  logic [NUM_SRC-1:0] evt_vec;
  logic               pend_any;
  logic [IDX_W-1:0]   win_idx;
  logic               take;
  logic               cmd_valid;
  uc_word_t           cmd;

  pwr_timewheel #(.TW_W(TW_W), .NUM_ALARMS(NUM_ALARMS)) tw_i (
    .clk(clk), .rst_n(rst_n), .wr(alarm_wr), .sel(alarm_sel),
    .cmp(alarm_cmp), .arm(alarm_arm), .oneshot(alarm_oneshot),
    .now(time_now), .armed(alarm_armed), .fire(tw_fire)
  );

  always_comb begin
    evt_vec             = '0;
    evt_vec[SRC_TIMER]  = tw_fire;
    evt_vec[SRC_RADIO]  = radio_evt;
    evt_vec[SRC_SENSOR] = sensor_evt;
    evt_vec[SRC_SW]     = sw_evt;
  end

  pwr_event_arb #(.NUM_SRC(NUM_SRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_vec), .take(take),
    .pend_any(pend_any), .win_idx(win_idx)
  );

  pwr_useq #(.UC_AW(UC_AW), .NSRC(NUM_SRC), .VEC_TABLE(VEC_TABLE)) seq_i (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .win_idx(win_idx),
    .uc_valid(uc_valid), .uc_addr(uc_addr), .uc_word(uc_word),
    .uc_ready(uc_ready), .take(take), .busy(busy),
    .cmd_valid(cmd_valid), .cmd(cmd)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic hit;
    assign hit = cmd_valid && (int'(cmd.unit) == u);

    pwr_unit_ctrl unit_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(hit),
      .cmd_lvl(cmd.lvl), .cmd_clk(cmd.clk_req),
      .supply(unit_supply[2*u +: 2]), .clk_en(unit_clk_en[u])
    );
  end

endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter int NUM_UNITS = 8,
  parameter int TW_W      = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   uc_ready,
  input logic [TW_W-1:0]        time_now,
  input logic [2*NUM_UNITS-1:0] unit_supply,
  input logic [NUM_UNITS-1:0]   unit_clk_en
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  a_r2_tick: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> time_now == $past(time_now) + 1'b1);

  // R9
  a_r9_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !uc_ready);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_u
    // R7
    a_r7_clk_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      unit_clk_en[g] |-> unit_supply[2*g +: 2] == 2'd2);
    // R7
    a_r7_clk_after_full: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $rose(unit_clk_en[g])) |-> $past(unit_supply[2*g +: 2]) == 2'd2);
    // R8
    a_r8_gate_then_lower: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(unit_supply[2*g +: 2]) == 2'd2 && unit_supply[2*g +: 2] != 2'd2)
        |-> !$past(unit_clk_en[g]));
    // R6
    a_r6_no_reserved_level: assert property (@(posedge clk) disable iff (!rst_n)
      unit_supply[2*g +: 2] != 2'd3);
  end

endmodule

bind pwr_supervisor pwr_supervisor_chk #(.NUM_UNITS(NUM_UNITS), .TW_W(TW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .uc_ready(uc_ready),
  .time_now(time_now), .unit_supply(unit_supply), .unit_clk_en(unit_clk_en)
);

// File: tb/pwr_supervisor_tb_top.sv
module pwr_supervisor_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        radio_evt = 0, sensor_evt = 0, sw_evt = 0;
  logic        alarm_wr = 0;
  logic [1:0]  alarm_sel = 0;
  logic [31:0] alarm_cmp = 0;
  logic        alarm_arm = 0, alarm_oneshot = 0;
  logic        uc_valid = 0;
  logic        uc_ready;
  logic [3:0]  uc_addr = 0;
  logic [6:0]  uc_word = 0;
  logic [31:0] time_now;
  logic [3:0]  alarm_armed;
  logic        busy;
  logic [15:0] unit_supply;
  logic [7:0]  unit_clk_en;

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_supervisor dut_i (
    .clk(clk), .rst_n(rst_n), .radio_evt(radio_evt), .sensor_evt(sensor_evt),
    .sw_evt(sw_evt), .alarm_wr(alarm_wr), .alarm_sel(alarm_sel),
    .alarm_cmp(alarm_cmp), .alarm_arm(alarm_arm), .alarm_oneshot(alarm_oneshot),
    .uc_valid(uc_valid), .uc_ready(uc_ready), .uc_addr(uc_addr), .uc_word(uc_word),
    .time_now(time_now), .alarm_armed(alarm_armed), .busy(busy),
    .unit_supply(unit_supply), .unit_clk_en(unit_clk_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] mkw(int unit, int lvl, bit ck, bit last);
    return {last, ck, 2'(lvl), 3'(unit)};
  endfunction

  function automatic logic [1:0] sup(int u);
    return unit_supply[2*u +: 2];
  endfunction

  // behavioural reference model
  logic [31:0] m_tw = 0;
  logic [31:0] m_cmp [4];
  bit          m_en [4];
  bit          m_os [4];
  bit   [3:0]  m_pend = 0;
  bit          m_run = 0;
  int          m_pc = 0;
  logic [6:0]  m_uc [16];
  int          m_sup [8];
  bit          m_clk [8];
  int          m_tl [8];
  bit          m_tc [8];

  task automatic model_reset();
    m_tw = 0; m_pend = 0; m_run = 0; m_pc = 0;
    for (int i = 0; i < 4; i++) begin m_cmp[i] = 0; m_en[i] = 0; m_os[i] = 0; end
    for (int a = 0; a < 16; a++) m_uc[a] = 7'h40;
    for (int u = 0; u < 8; u++) begin m_sup[u] = 0; m_clk[u] = 0; m_tl[u] = 0; m_tc[u] = 0; end
  endtask

  task automatic model_step();
    bit hit [4];
    bit fire = 0;
    bit was_run = m_run;
    logic [6:0] w = m_uc[m_pc];
    for (int i = 0; i < 4; i++) begin
      hit[i] = m_en[i] && (m_tw == m_cmp[i]);
      if (hit[i]) fire = 1;
    end
    for (int u = 0; u < 8; u++) begin
      if (m_run && int'(w[2:0]) == u) begin
        m_tl[u] = (w[4:3] == 2'd3) ? 2 : int'(w[4:3]);
        m_tc[u] = w[5];
      end
      if (m_clk[u] && (m_tl[u] != 2 || !m_tc[u])) m_clk[u] = 0;
      else if (m_sup[u] != m_tl[u]) m_sup[u] = m_tl[u];
      else if (m_tc[u] && m_tl[u] == 2) m_clk[u] = 1;
    end
    if (!m_run) begin
      if (m_pend != 0) begin
        int p = 0;
        for (int k = 3; k >= 0; k--) if (m_pend[k]) p = k;
        m_pend[p] = 0;
        m_pc = p * 4;
        m_run = 1;
      end
    end else if (w[6]) m_run = 0;
    else m_pc = (m_pc + 1) % 16;
    m_pend = m_pend | {sw_evt, sensor_evt, radio_evt, fire};
    if (uc_valid && !was_run) m_uc[uc_addr] = uc_word;
    for (int i = 0; i < 4; i++) begin
      if (alarm_wr && int'(alarm_sel) == i) begin
        m_cmp[i] = alarm_cmp; m_en[i] = alarm_arm; m_os[i] = alarm_oneshot;
      end else if (hit[i] && m_os[i]) m_en[i] = 0;
    end
    m_tw = m_tw + 1;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R2 time_now", time_now, m_tw);
      for (int i = 0; i < 4; i++) chk("R3 alarm_armed", 32'(alarm_armed[i]), 32'(m_en[i]));
      chk("R4 busy", 32'(busy), 32'(m_run));
      chk("R9 uc_ready", 32'(uc_ready), 32'(!m_run));
      for (int u = 0; u < 8; u++) begin
        chk("R6 unit_supply", 32'(sup(u)), 32'(m_sup[u]));
        chk("R7 unit_clk_en", 32'(unit_clk_en[u]), 32'(m_clk[u]));
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic uc_load(int addr, logic [6:0] w);
    uc_valid = 1; uc_addr = 4'(addr); uc_word = w;
    @(negedge clk);
    uc_valid = 0;
  endtask

  task automatic alarm_set(int sel, logic [31:0] c, bit arm, bit os);
    alarm_wr = 1; alarm_sel = 2'(sel); alarm_cmp = c; alarm_arm = arm; alarm_oneshot = os;
    @(negedge clk);
    alarm_wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] t0;
    logic [15:0] sup_snap;
    logic [7:0]  clk_snap;
    #2 rst_n = 0;
    cyc(3);
    // R1 reset state
    chk("R1 supply", 32'(unit_supply), 0);
    chk("R1 clk", 32'(unit_clk_en), 0);
    chk("R1 armed", 32'(alarm_armed), 0);
    chk("R1 time", time_now, 0);
    chk("R1 ready", 32'(uc_ready), 1);
    rst_n = 1;
    cmp_on = 1;
    cyc(1);

    uc_load(0,  mkw(1, 2, 1, 0));
    uc_load(1,  mkw(2, 1, 0, 1));
    uc_load(4,  mkw(3, 2, 1, 1));
    uc_load(8,  mkw(3, 0, 0, 1));
    uc_load(12, mkw(5, 1, 1, 0));
    uc_load(13, mkw(6, 3, 1, 1));
    cyc(2);

    // R4 idle: no events, nothing moves
    sup_snap = unit_supply; clk_snap = unit_clk_en;
    cyc(20);
    chk("R4 idle supply", 32'(unit_supply), 32'(sup_snap));
    chk("R4 idle clk", 32'(unit_clk_en), 32'(clk_snap));
    chk("R4 idle busy", 32'(busy), 0);

    // radio event: unit3 raised, clock one cycle later (R6, R7)
    radio_evt = 1; cyc(1);
    radio_evt = 0; cyc(1);
    chk("R9 ready low while busy", 32'(uc_ready), 0);
    uc_valid = 1; uc_addr = 4'd4; uc_word = mkw(4, 2, 1, 1);
    cyc(1);
    uc_valid = 0;
    chk("R6 first word two edges after latch", 32'(sup(3)), 2);
    chk("R7 clock still gated at full", 32'(unit_clk_en[3]), 0);
    cyc(1);
    chk("R7 clock on after full", 32'(unit_clk_en[3]), 1);
    cyc(4);

    // sensor event: gate first, lower next (R8)
    sensor_evt = 1; cyc(1);
    sensor_evt = 0; cyc(2);
    chk("R8 clock gated first", 32'(unit_clk_en[3]), 0);
    chk("R8 supply held one cycle", 32'(sup(3)), 2);
    cyc(1);
    chk("R8 supply lowered", 32'(sup(3)), 0);
    cyc(4);

    // simultaneous radio, sensor, software: order decides unit3 (R5)
    radio_evt = 1; sensor_evt = 1; sw_evt = 1; cyc(1);
    radio_evt = 0; sensor_evt = 0; sw_evt = 0;
    cyc(15);
    chk("R5 radio before sensor leaves unit3 off", 32'(sup(3)), 0);
    chk("R5 unit3 clock", 32'(unit_clk_en[3]), 0);
    chk("R10 retention with clock request", 32'(sup(5)), 1);
    chk("R10 clock stays gated", 32'(unit_clk_en[5]), 0);
    chk("R6 level code 3 applied as full", 32'(sup(6)), 2);
    chk("R6 unit6 clock", 32'(unit_clk_en[6]), 1);

    // alarms (R3)
    t0 = time_now;
    alarm_set(2, t0 + 15, 1, 1);
    alarm_set(1, t0 + 30, 1, 0);
    cyc(40);
    chk("R3 one-shot disarmed", 32'(alarm_armed[2]), 0);
    chk("R3 periodic still armed", 32'(alarm_armed[1]), 1);
    chk("R3 timer sequence unit1 supply", 32'(sup(1)), 2);
    chk("R3 timer sequence unit1 clock", 32'(unit_clk_en[1]), 1);
    chk("R3 timer sequence unit2 retention", 32'(sup(2)), 1);

    // timer and sensor land on the same edge (R5)
    t0 = time_now;
    alarm_set(0, t0 + 4, 1, 1);
    cyc(3);
    sensor_evt = 1; cyc(1);
    sensor_evt = 0;
    cyc(12);
    chk("R5 timer alarm consumed", 32'(alarm_armed[0]), 0);
    chk("R5 sensor served after timer", 32'(sup(3)), 0);

    // R2 tick rate
    t0 = time_now;
    cyc(10);
    chk("R2 ten ticks", time_now, t0 + 10);

    // R9 the word offered while busy never reached address 4
    radio_evt = 1; cyc(1);
    radio_evt = 0; cyc(8);
    chk("R9 rejected write left unit4 off", 32'(sup(4)), 0);
    chk("R9 original word ran", 32'(sup(3)), 2);

    cyc(2);
    finish_run();
  end

endmodule